// File: doc/BRIEF.md
# Immediate and Register-Move Execute Unit

This unit executes two instruction forms of a small 16-bit machine with four general registers (A, B, C, D). The immediate form loads or accumulates an 8-bit constant into a chosen register. Two mode bits pick zero or sign extension, an optional shift into the upper byte, and whether the result replaces the register or is added to it. A move-low followed by an add-high therefore builds any 16-bit constant.

The register-move form copies one register into another and adds a sign-extended 8-bit addend on the way. A single encoding covers plain copy, increment and decrement. Each instruction is presented as a 16-bit word with a valid strobe. The register file is updated on the clock edge at which the strobe is high. All four registers are visible on debug read ports. Any other opcode leaves the state alone and raises a one-cycle flag.

Top module: `imm_move_exec`

## Requirements
- R1: After synchronous reset, all four registers read 0x0000 and the unsupported flag is low.
- R2: The opcode is word bits [3:0]. Opcode 0x1 is the immediate form: destination index in bits [5:4] (0=A, 1=B, 2=C, 3=D), mode in bits [7:6], and the 8-bit constant in bits [15:8].
- R3: Immediate mode 0 writes the zero-extended constant to the destination.
- R4: Immediate mode 1 adds the sign-extended constant to the destination, modulo 2^16.
- R5: Immediate mode 2 writes the constant shifted left by 8, with the low byte zero.
- R6: Immediate mode 3 adds the constant shifted left by 8 to the destination, modulo 2^16. A mode 0 with low byte L followed by a mode 3 with byte H leaves the register equal to {H,L}.
- R7: Opcode 0x0 is the register move: source index in bits [7:6], destination index in bits [5:4], and a signed addend in bits [15:8]. The destination becomes source + sext(addend), modulo 2^16. Addend 0x00 copies the source; with source equal to destination, 0x01 increments and 0xFF decrements.
- R8: A write happens on the clock edge where valid is high, and the new value appears on the debug ports in the following cycle. Registers other than the destination are unchanged, and nothing changes while valid is low.
- R9: A word with valid high and an opcode other than 0x0 or 0x1 leaves every register unchanged. It drives the unsupported flag high for exactly the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction word strobe |
| insn_word | input | 16 | Instruction word |
| reg_a | output | 16 | Register A debug read |
| reg_b | output | 16 | Register B debug read |
| reg_c | output | 16 | Register C debug read |
| reg_d | output | 16 | Register D debug read |
| bad_op | output | 1 | One-cycle flag for an unsupported opcode |

## Verification
The assertions assume that insn_word carries defined bits whenever insn_valid is high. They also assume the strobe may be high on any cycle, including back-to-back cycles, so each property compares a register with its value one cycle earlier. The random stimulus draws every word from $urandom with a fixed seed and holds valid low for a random share of cycles. Words with opcode values 2 to 15 are mixed in so that the unsupported path and its no-write property are exercised. Directed sequences cover increment and decrement, carries across the byte boundary, wrap-around, and the two-step 16-bit constant load.

// File: rtl/imm_move_pkg.sv
package imm_move_pkg;
  localparam int XLEN    = 16;
  localparam int NREG    = 4;
  localparam int RIDX_W  = $clog2(NREG);
  localparam int IMM_W   = 8;
  localparam int OPC_W   = 4;

  typedef enum logic [OPC_W-1:0] {
    OPC_RMOVE = 4'h0,
    OPC_IMM   = 4'h1
  } opc_e;

  typedef struct packed {
    logic [IMM_W-1:0]  imm;
    logic [RIDX_W-1:0] sel;   // mode (imm form) or source (move form)
    logic [RIDX_W-1:0] dst;
    logic [OPC_W-1:0]  opc;
  } insn_t;

  typedef struct packed {
    logic              we;
    logic [RIDX_W-1:0] dst;
    logic [XLEN-1:0]   val;
    logic              bad;
  } wb_t;
endpackage

// File: rtl/imm_move_decode.sv
module imm_move_decode
  import imm_move_pkg::*;
(
  input  logic             valid,
  input  logic [XLEN-1:0]  word,
  output logic             is_imm,
  output logic             is_move,
  output logic             is_bad,
  output insn_t            fields
);
  assign fields  = insn_t'(word);
  assign is_imm  = valid && (fields.opc == OPC_IMM);
  assign is_move = valid && (fields.opc == OPC_RMOVE);
  assign is_bad  = valid && !is_imm && !is_move;
endmodule

// File: rtl/imm_move_alu.sv
module imm_move_alu
  import imm_move_pkg::*;
(
  input  logic             is_imm,
  input  insn_t            fields,
  input  logic [XLEN-1:0]  dst_val,
  input  logic [XLEN-1:0]  src_val,
  output logic [XLEN-1:0]  result
);
  localparam int EXT_W = XLEN - IMM_W;

  logic [XLEN-1:0] sext_imm, zext_imm, operand, base;
  logic            accumulate, upper;

  assign sext_imm = {{EXT_W{fields.imm[IMM_W-1]}}, fields.imm};
  assign zext_imm = {{EXT_W{1'b0}}, fields.imm};

  always_comb begin
    if (is_imm) begin
      accumulate = fields.sel[0];
      upper      = fields.sel[1];
      operand    = accumulate ? sext_imm : zext_imm;
      if (upper) operand = operand << IMM_W;
      base       = accumulate ? dst_val : '0;
    end else begin
      accumulate = 1'b1;
      upper      = 1'b0;
      operand    = sext_imm;
      base       = src_val;
    end
    result = base + operand;
  end
endmodule

// File: rtl/imm_move_regfile.sv
module imm_move_regfile
  import imm_move_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [RIDX_W-1:0]    waddr,
  input  logic [XLEN-1:0]      wdata,
  input  logic [RIDX_W-1:0]    raddr0,
  input  logic [RIDX_W-1:0]    raddr1,
  output logic [XLEN-1:0]      rdata0,
  output logic [XLEN-1:0]      rdata1,
  output logic [NREG*XLEN-1:0] all_regs
);
  logic [XLEN-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) regs[g] <= '0;
      else if (we && waddr == RIDX_W'(g)) regs[g] <= wdata;
    end
    assign all_regs[g*XLEN +: XLEN] = regs[g];

    assert property (@(posedge clk) disable iff (rst)
      !(we && waddr == RIDX_W'(g)) |=> $stable(regs[g]))
      else $error("assert_untouched_stable_R8 reg %0d", g);
  end

  assign rdata0 = regs[raddr0];
  assign rdata1 = regs[raddr1];
endmodule

// File: rtl/imm_move_exec.sv
module imm_move_exec
  import imm_move_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        insn_valid,
  input  logic [15:0] insn_word,
  output logic [15:0] reg_a,
  output logic [15:0] reg_b,
  output logic [15:0] reg_c,
  output logic [15:0] reg_d,
  output logic        bad_op
);
  logic            is_imm, is_move, is_bad;
  insn_t           f;
  logic [XLEN-1:0] dst_val, src_val, result;
  logic [NREG*XLEN-1:0] regs_flat;
  logic            bad_q;

  imm_move_decode u_dec (
    .valid(insn_valid), .word(insn_word),
    .is_imm(is_imm), .is_move(is_move), .is_bad(is_bad), .fields(f)
  );

  imm_move_regfile u_rf (
    .clk(clk), .rst(rst),
    .we(is_imm || is_move), .waddr(f.dst), .wdata(result),
    .raddr0(f.dst), .raddr1(f.sel),
    .rdata0(dst_val), .rdata1(src_val),
    .all_regs(regs_flat)
  );

  imm_move_alu u_alu (
    .is_imm(is_imm), .fields(f),
    .dst_val(dst_val), .src_val(src_val), .result(result)
  );

  always_ff @(posedge clk) begin
    if (rst) bad_q <= 1'b0;
    else     bad_q <= is_bad;
  end

  assign reg_a  = regs_flat[0*XLEN +: XLEN];
  assign reg_b  = regs_flat[1*XLEN +: XLEN];
  assign reg_c  = regs_flat[2*XLEN +: XLEN];
  assign reg_d  = regs_flat[3*XLEN +: XLEN];
  assign bad_op = bad_q;

  assert property (@(posedge clk) disable iff (rst)
    (insn_valid && insn_word[3:0] > 4'h1) |=> bad_op && $stable(regs_flat))
    else $error("assert_bad_opcode_R9");

  assert property (@(posedge clk) disable iff (rst)
    !insn_valid |=> !bad_op && $stable(regs_flat))
    else $error("assert_idle_hold_R8");

  assert property (@(posedge clk) disable iff (rst)
    (insn_valid && insn_word[3:0] == 4'h1 && insn_word[7:6] == 2'd2)
      |=> regs_flat[16*$past(insn_word[5:4]) +: 8] == 8'h00)
    else $error("assert_upper_low_zero_R5");

  assert property (@(posedge clk) disable iff (rst)
    (insn_valid && insn_word[3:0] == 4'h0 && insn_word[15:8] == 8'h00)
      |=> regs_flat[16*$past(insn_word[5:4]) +: 16] ==
          $past(regs_flat[16*insn_word[7:6] +: 16]))
    else $error("assert_plain_copy_R7");

  assert property (@(posedge clk) $rose(rst) |=> regs_flat == '0 && !bad_op)
    else $error("assert_reset_clear_R1");
endmodule

// File: tb/imm_move_exec_test.sv
module imm_move_exec_test;
  logic clk = 1'b0;
  logic rst;
  logic insn_valid;
  logic [15:0] insn_word;
  logic [15:0] reg_a, reg_b, reg_c, reg_d;
  logic bad_op;

  int n_cmp = 0, n_bad = 0;
  logic [15:0] model [4];
  logic exp_bad;

  always #4 clk = ~clk;

  imm_move_exec uut (
    .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn_word(insn_word),
    .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c), .reg_d(reg_d), .bad_op(bad_op)
  );

  function automatic logic [15:0] sx(input logic [7:0] v);
    return {{8{v[7]}}, v};
  endfunction

  // R2..R7 behavioural model
  function automatic void apply(input logic v, input logic [15:0] w);
    logic [1:0] d, s;
    logic [7:0] imm;
    d = w[5:4]; s = w[7:6]; imm = w[15:8];
    exp_bad = 1'b0;
    if (!v) return;
    case (w[3:0])
      4'h1: case (s)
        2'd0: model[d] = {8'h00, imm};
        2'd1: model[d] = model[d] + sx(imm);
        2'd2: model[d] = {imm, 8'h00};
        2'd3: model[d] = model[d] + {imm, 8'h00};
        default: ;
      endcase
      4'h0: model[d] = model[s] + sx(imm);
      default: exp_bad = 1'b1;
    endcase
  endfunction

  task automatic check(input string req);
    logic [15:0] got [4];
    got[0] = reg_a; got[1] = reg_b; got[2] = reg_c; got[3] = reg_d;
    for (int i = 0; i < 4; i++) begin
      n_cmp++;
      if (got[i] !== model[i]) begin
        n_bad++;
        $display("FAIL %s reg%0d actual %h expected %h", req, i, got[i], model[i]);
      end
    end
    n_cmp++;
    if (bad_op !== exp_bad) begin
      n_bad++;
      $display("FAIL %s bad_op actual %b expected %b", req, bad_op, exp_bad);
    end
  endtask

  // drive at negedge, edge commits, check at next negedge
  task automatic issue(input logic v, input logic [15:0] w, input string req);
    insn_valid = v; insn_word = w;
    apply(v, w);
    @(negedge clk);
    check(req);
  endtask

  function automatic logic [15:0] imm_w(input logic [1:0] m, input logic [1:0] d, input logic [7:0] i);
    return {i, m, d, 4'h1};
  endfunction
  function automatic logic [15:0] mv_w(input logic [1:0] s, input logic [1:0] d, input logic [7:0] i);
    return {i, s, d, 4'h0};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; insn_valid = 1'b0; insn_word = '0;
    for (int i = 0; i < 4; i++) model[i] = '0;
    exp_bad = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1");
    issue(1'b1, imm_w(2'd0, 2'd0, 8'hF3), "R3");
    issue(1'b1, imm_w(2'd1, 2'd0, 8'h20), "R4");
    issue(1'b1, imm_w(2'd1, 2'd0, 8'hFF), "R4");
    issue(1'b1, imm_w(2'd2, 2'd1, 8'hA5), "R5");
    issue(1'b1, imm_w(2'd0, 2'd2, 8'h34), "R6");
    issue(1'b1, imm_w(2'd3, 2'd2, 8'h12), "R6");
    n_cmp++;
    if (reg_c !== 16'h1234) begin n_bad++; $display("FAIL R6 actual %h expected 1234", reg_c); end
    issue(1'b1, imm_w(2'd3, 2'd2, 8'hF0), "R6");
    issue(1'b1, mv_w(2'd2, 2'd3, 8'h00), "R7");
    issue(1'b1, mv_w(2'd3, 2'd3, 8'h01), "R7");
    issue(1'b1, mv_w(2'd3, 2'd3, 8'hFF), "R7");
    issue(1'b1, mv_w(2'd1, 2'd0, 8'h80), "R7");
    issue(1'b1, imm_w(2'd0, 2'd3, 8'h00), "R3");
    issue(1'b1, mv_w(2'd3, 2'd3, 8'hFF), "R7");
    issue(1'b0, imm_w(2'd0, 2'd0, 8'h55), "R8");
    issue(1'b1, 16'hFFF7, "R9");
    issue(1'b0, 16'h0000, "R9");
    issue(1'b1, 16'h1232, "R9");
    issue(1'b1, imm_w(2'd1, 2'd1, 8'h7F), "R2");
    for (int k = 0; k < 3000; k++) begin
      logic [15:0] w;
      logic v;
      w = 16'($urandom);
      if ($urandom_range(0, 3) != 0) w[3:1] = 3'd0;
      v = ($urandom_range(0, 4) != 0);
      issue(v, w, "R8");
    end
    rst = 1'b1; insn_valid = 1'b0;
    for (int i = 0; i < 4; i++) model[i] = '0;
    exp_bad = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule